// File: doc/BRIEF.md
# Configuration Mode Entry and Reload Sequencer

This block decides when a gate pre-driver leaves normal operation and hands its shared pins to a serial configuration port, and it sequences the way back. Configuration mode is entered only while the driver is disabled, no diagnostic report is waiting, every high-side control input is high and every low-side control input is low. On top of that pin state, the error line must carry one low pulse whose width falls inside a fixed window of clock periods. The width is judged when the rising edge that ends the pulse arrives.

Raising enable ends configuration mode. The block then waits until any nonvolatile write in progress has finished. It issues a single-cycle request to copy the nonvolatile contents into the working registers and waits for the copy to report done. During this whole interval it pulls the error line low and keeps the gate driver blocked. After power-on reset the block runs the same wait-and-copy sequence before normal mode begins. The serial shift engine and the memory array are outside the block; handshake signals stand in for them.

Top module: `cfg_mode_seq`

## Requirements
- R1: Directly after reset, cfg_mode_o is 0, err_hold_low_o is 1 and drv_block_o is 1.
- R2: After reset, copy_start_o pulses in the cycle after nv_busy_i is first seen low. Normal mode (drv_block_o=0, err_hold_low_o=0) follows the cycle in which copy_done_i is seen high.
- R3: In normal mode, with the pin state qualifying, an error-line low pulse lasting between MIN_LOW and MAX_LOW clock periods (inclusive) sets cfg_mode_o in the cycle after the line returns high.
- R4: A qualifying low pulse shorter than MIN_LOW periods is ignored, and cfg_mode_o stays 0.
- R5: A qualifying low pulse longer than MAX_LOW periods is ignored, and cfg_mode_o stays 0.
- R6: While en_i is 1 no pulse causes entry.
- R7: While err_pending_i is 1 no pulse causes entry.
- R8: Entry needs every bit of hs_ctl_i at 1 and every bit of ls_ctl_i at 0. Any other pattern prevents entry.
- R9: If the pin state stops qualifying for any cycle during a pulse, that pulse is discarded, even when the pin state qualifies again before the pulse ends.
- R10: In configuration mode, en_i=1 clears cfg_mode_o on the next cycle and sets err_hold_low_o. No copy is requested while nv_busy_i is 1.
- R11: Each exit yields exactly one single-cycle copy_start_o. The driver is released only after copy_done_i.
- R12: drv_block_o is 1 whenever cfg_mode_o or err_hold_low_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Driver enable |
| hs_ctl_i | input | N_PH | High-side gate control inputs |
| ls_ctl_i | input | N_PH | Low-side gate control inputs |
| err_line_i | input | 1 | Sensed level of the error line |
| err_pending_i | input | 1 | Error reporter has unacknowledged reports |
| nv_busy_i | input | 1 | Nonvolatile write in progress |
| copy_done_i | input | 1 | Register copy finished |
| copy_start_o | output | 1 | One-cycle request to copy nonvolatile contents |
| cfg_mode_o | output | 1 | Configuration mode active |
| err_hold_low_o | output | 1 | Pull error line low |
| drv_block_o | output | 1 | Gate driver blocked |

## Verification
The bench builds the block with MIN_LOW=8 and MAX_LOW=16 rather than the window of several thousand cycles. This puts both window edges, the widths one period outside them and the counter saturation within a few dozen cycles. With these values each disqualifying pin pattern and the mid-pulse abort can be run individually, and the full exit and reload handshake can be run after every entry.

// File: rtl/cfg_mode_pkg.sv
package cfg_mode_pkg;
  typedef enum logic [2:0] {
    ST_DRAIN = 3'd0,
    ST_KICK  = 3'd1,
    ST_COPY  = 3'd2,
    ST_RUN   = 3'd3,
    ST_CFG   = 3'd4
  } seq_state_e;
endpackage

// File: rtl/cfg_entry_qual.sv
module cfg_entry_qual #(
  parameter int N_PH = 3
) (
  input  logic            en_i,
  input  logic            err_pending_i,
  input  logic [N_PH-1:0] hs_ctl_i,
  input  logic [N_PH-1:0] ls_ctl_i,
  output logic            qual_o
);
  assign qual_o = !en_i && !err_pending_i && (&hs_ctl_i) && !(|ls_ctl_i);
endmodule

// File: rtl/cfg_pulse_meter.sv
module cfg_pulse_meter #(
  parameter int MIN_LOW = 2048,
  parameter int MAX_LOW = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic line_i,
  output logic hit_o
);
  localparam int CW = $clog2(MAX_LOW + 2);
  localparam logic [CW-1:0] SAT = CW'(MAX_LOW + 1);
  localparam logic [CW-1:0] LO  = CW'(MIN_LOW);
  localparam logic [CW-1:0] HI  = CW'(MAX_LOW);

  logic          line_q, meas_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= 1'b1;
      meas_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      line_q <= line_i;
      if (!arm_i) begin
        meas_q <= 1'b0;
        cnt_q  <= '0;
      end else if (meas_q) begin
        if (line_i) begin
          meas_q <= 1'b0;
          cnt_q  <= '0;
        end else if (cnt_q != SAT) begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (line_q && !line_i) begin
        // only a fresh falling edge starts a measurement
        meas_q <= 1'b1;
        cnt_q  <= CW'(1);
      end
    end
  end

  assign hit_o = arm_i && meas_q && line_i && (cnt_q >= LO) && (cnt_q <= HI);

  AST_HIT_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (line_i && !line_q)) else $error("hit without rising edge"); // R3
  AST_CNT_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= SAT) else $error("counter overflow"); // R5
endmodule

// File: rtl/cfg_seq_fsm.sv
module cfg_seq_fsm
  import cfg_mode_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic en_i,
  input  logic nv_busy_i,
  input  logic copy_done_i,
  output logic run_o,
  output logic copy_start_o,
  output logic cfg_mode_o,
  output logic err_hold_low_o,
  output logic drv_block_o
);
  seq_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_DRAIN: if (!nv_busy_i)  st_d = ST_KICK;
      ST_KICK:                   st_d = ST_COPY;
      ST_COPY:  if (copy_done_i) st_d = ST_RUN;
      ST_RUN:   if (hit_i)       st_d = ST_CFG;
      ST_CFG:   if (en_i)        st_d = ST_DRAIN;
      default:                   st_d = ST_DRAIN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_DRAIN;
    else         st_q <= st_d;
  end

  assign run_o          = (st_q == ST_RUN);
  assign copy_start_o   = (st_q == ST_KICK);
  assign cfg_mode_o     = (st_q == ST_CFG);
  assign err_hold_low_o = (st_q == ST_DRAIN) || (st_q == ST_KICK) || (st_q == ST_COPY);
  assign drv_block_o    = !run_o;

  AST_START_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    copy_start_o |=> !copy_start_o) else $error("copy start too long"); // R11
  AST_START_AFTER_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(copy_start_o) |-> $past(!nv_busy_i)) else $error("copy during write"); // R10
  AST_RELEASE_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(drv_block_o) |-> $past(copy_done_i)) else $error("early release"); // R11
endmodule

// File: rtl/cfg_mode_seq.sv
module cfg_mode_seq #(
  parameter int N_PH    = 3,
  parameter int MIN_LOW = 2048,
  parameter int MAX_LOW = 4096
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [N_PH-1:0] hs_ctl_i,
  input  logic [N_PH-1:0] ls_ctl_i,
  input  logic            err_line_i,
  input  logic            err_pending_i,
  input  logic            nv_busy_i,
  input  logic            copy_done_i,
  output logic            copy_start_o,
  output logic            cfg_mode_o,
  output logic            err_hold_low_o,
  output logic            drv_block_o
);
  logic qual, run, hit;

  cfg_entry_qual #(.N_PH(N_PH)) u_qual (
    .en_i          (en_i),
    .err_pending_i (err_pending_i),
    .hs_ctl_i      (hs_ctl_i),
    .ls_ctl_i      (ls_ctl_i),
    .qual_o        (qual)
  );

  cfg_pulse_meter #(.MIN_LOW(MIN_LOW), .MAX_LOW(MAX_LOW)) u_meter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .arm_i  (qual && run),
    .line_i (err_line_i),
    .hit_o  (hit)
  );

  cfg_seq_fsm u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .hit_i          (hit),
    .en_i           (en_i),
    .nv_busy_i      (nv_busy_i),
    .copy_done_i    (copy_done_i),
    .run_o          (run),
    .copy_start_o   (copy_start_o),
    .cfg_mode_o     (cfg_mode_o),
    .err_hold_low_o (err_hold_low_o),
    .drv_block_o    (drv_block_o)
  );

  AST_ENTRY_EN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_mode_o) |-> $past(!en_i && !err_pending_i)) else $error("bad entry"); // R6
  AST_ENTRY_PINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_mode_o) |-> $past((&hs_ctl_i) && !(|ls_ctl_i))) else $error("bad pins"); // R8
  AST_BLOCK_CFG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_mode_o || err_hold_low_o) |-> drv_block_o) else $error("driver free"); // R12
  AST_EXIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_mode_o && en_i) |=> (!cfg_mode_o && err_hold_low_o)) else $error("exit"); // R10
endmodule

// File: tb/cfg_mode_seq_tb_top.sv
module cfg_mode_seq_tb_top;
  localparam int N_PH = 3;
  localparam int MINL = 8;
  localparam int MAXL = 16;
  localparam int NV   = 5;
  localparam int WID [NV] = '{7, 8, 12, 16, 17};
  localparam bit EXP [NV] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0};

  logic clk = 1'b0, rst_n = 1'b0;
  logic en, err_line, pend, busy, done;
  logic [N_PH-1:0] hs, ls;
  logic copy_start, cfg_mode, hold_low, blk;
  int checks = 0, errors = 0, starts = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  cfg_mode_seq #(.N_PH(N_PH), .MIN_LOW(MINL), .MAX_LOW(MAXL)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .hs_ctl_i(hs), .ls_ctl_i(ls),
    .err_line_i(err_line), .err_pending_i(pend), .nv_busy_i(busy),
    .copy_done_i(done), .copy_start_o(copy_start), .cfg_mode_o(cfg_mode),
    .err_hold_low_o(hold_low), .drv_block_o(blk)
  );

  always @(negedge clk) if (rst_n && copy_start) starts++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle_pins();
    en = 1'b0; pend = 1'b0; hs = '1; ls = '0;
  endtask

  task automatic pulse(input int w);
    err_line = 1'b0;
    repeat (w) @(negedge clk);
    err_line = 1'b1;
    @(negedge clk);
  endtask

  task automatic reload(input string req);
    int s0;
    s0 = starts;
    busy = 1'b1;
    repeat (3) @(negedge clk);
    chk({req, " no copy while busy"}, copy_start, 0);
    chk({req, " hold low"}, hold_low, 1);
    busy = 1'b0;
    @(negedge clk);
    chk({req, " copy start"}, copy_start, 1);
    @(negedge clk);
    chk({req, " start single"}, copy_start, 0);
    chk({req, " blocked before done"}, blk, 1);
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    chk({req, " released"}, blk, 0);
    chk({req, " hold released"}, hold_low, 0);
    chk({req, " one start"}, starts - s0, 1);
  endtask

  task automatic exit_cfg();
    en = 1'b1;
    busy = 1'b1;
    @(negedge clk);
    chk("R10 cfg cleared", cfg_mode, 0);
    chk("R10 hold on exit", hold_low, 1);
    chk("R12 blocked on exit", blk, 1);
    reload("R11");
    idle_pins();
    @(negedge clk);
  endtask

  initial begin
    idle_pins();
    err_line = 1'b1; busy = 1'b1; done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cfg_mode", cfg_mode, 0);
    chk("R1 hold", hold_low, 1);
    chk("R1 block", blk, 1);
    reload("R2");
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      pulse(WID[i]);
      chk($sformatf("%s width %0d", (WID[i] < MINL) ? "R4" : (WID[i] > MAXL) ? "R5" : "R3", WID[i]),
          cfg_mode, EXP[i]);
      if (cfg_mode) begin
        chk("R12 blocked in cfg", blk, 1);
        exit_cfg();
      end
      @(negedge clk);
    end

    en = 1'b1; pulse(12); chk("R6 enable high", cfg_mode, 0); idle_pins(); @(negedge clk);
    pend = 1'b1; pulse(12); chk("R7 pending", cfg_mode, 0); idle_pins(); @(negedge clk);
    hs[1] = 1'b0; pulse(12); chk("R8 high-side low", cfg_mode, 0); idle_pins(); @(negedge clk);
    ls[2] = 1'b1; pulse(12); chk("R8 low-side high", cfg_mode, 0); idle_pins(); @(negedge clk);

    err_line = 1'b0;
    repeat (4) @(negedge clk);
    ls[0] = 1'b1;
    @(negedge clk);
    ls[0] = 1'b0;
    repeat (7) @(negedge clk);
    err_line = 1'b1;
    @(negedge clk);
    chk("R9 aborted pulse", cfg_mode, 0);
    chk("R12 driver free in normal", blk, 0);

    pulse(MAXL);
    chk("R3 entry after abort", cfg_mode, 1);
    exit_cfg();

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule